// File: doc/BRIEF.md
# Two-Player Serial Gamepad Poller

This block reads two serial game controllers of the common 16-bit console kind. The controllers share one latch line and one clock line, and each has its own data line. The block makes the controllers' button state available to a CPU through three word registers on a 16-bit bus. Software writes the control word to start a poll and reads the status word until the busy bit clears. It then reads one 16-bit word per player, in which a pressed button is a 1.

A free-running phase accumulator sets the pace of the serial lines. On every system clock a 32-bit accumulator adds a fixed step, and the carry out becomes a one-cycle strobe. The default step of 14316557 on a 50 MHz clock gives a strobe of about 166.7 kHz. The sequencer runs on the system clock and moves forward only on strobe cycles. Every line phase therefore lasts exactly one strobe period.

The block returns zero on its read-data output whenever it is not serving a selected read cycle. This lets its output be OR-ed with the outputs of other bus devices.

Top module: `pad_poll_bus`

## Requirements
- R1: After a synchronous reset, `pad_latch` is 0, `pad_clk` is 1, `bus_rdata` is 0, the busy bit is 0 and both player words read as 0.
- R2: A cycle with `bus_cs`=1, `bus_rd`=0 and `bus_addr`=2'b00 starts a poll. The busy bit is set from the next clock edge, so a status read issued on the following cycle returns bit 0 = 1.
- R3: A write with `bus_cs`=0, or a selected write to `bus_addr` other than 2'b00, starts no poll. No latch pulse is produced and the busy bit stays 0.
- R4: A start write that arrives while a poll is busy is ignored. A poll produces exactly one latch pulse.
- R5: Within a poll, `pad_latch` is high for exactly one strobe period and then low. After that, `pad_clk` gives 16 pulses, and each low phase and each high phase lasts one strobe period.
- R6: Each data line is sampled on the strobe edge where `pad_clk` is driven low. Data is active low, so it is stored inverted. The bit present right after the latch lands in bit 0, and later bits fill the higher bits in arrival order. The button layout is: bit 0 = B, bit 1 = Y, bit 2 = Select, bit 3 = Start, bit 4 = Up, bit 5 = Down, bit 6 = Left, bit 7 = Right, bit 8 = A, bit 9 = X, bit 10 = L, bit 11 = R, and bits 12 to 15 take the four clocks that follow.
- R7: One poll captures both players from the same latch and clock, using `pad_data[0]` for player 1 and `pad_data[1]` for player 2. Both player words update on the 16th sample. The busy bit clears one strobe period later.
- R8: Read mapping by `bus_addr`:
  - 2'b00 returns the status word: bit 0 is busy and all other bits are 0.
  - 2'b01 returns player 1.
  - 2'b10 returns player 2.
  - 2'b11 returns 0.

  `bus_rdata` is registered and appears one clock after the read cycle.
- R9: `bus_rdata` is 0 on every cycle that does not follow a cycle with `bus_cs`=1 and `bus_rd`=1.
- R10: The strobe is the carry out of an accumulator of width `ACC_W` that adds `ACC_STEP` every clock. With `ACC_STEP` = 2^30 and `ACC_W` = 32, the strobe recurs every 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Block selected for this bus cycle |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 2 | Word index (byte address bits 2:1) |
| bus_rdata | output | 16 | Registered read data, 0 when idle |
| pad_latch | output | 1 | Shared controller latch line |
| pad_clk | output | 1 | Shared controller clock line, idles high |
| pad_data | input | 2 | Per-player serial data, active low |

## Verification
Three functions can land on the same clock edge.

A start write can arrive in the middle of a poll, while the sequencer is already busy. The bench provokes this by issuing a second control write about twenty cycles into a poll. It then judges the outcome at the pins: it counts latch rising edges, which must show one pulse, and it checks that the player words still match the stimulus of the first poll.

A status or player read can also coincide with the capture of the 16th bit. The bench covers this by polling the status word back-to-back throughout every poll. Each final player read must equal the value that the bench's own function computes from the pressed-button vectors.

// File: rtl/pad_poll_pkg.sv
package pad_poll_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ARM,
    SQ_LATCH,
    SQ_FALL,
    SQ_RISE
  } seq_state_t;

  localparam logic [1:0] OFS_CTRL = 2'b00;
endpackage

// File: rtl/pad_tick_gen.sv
module pad_tick_gen #(
  parameter int unsigned      ACC_W    = 32,
  parameter longint unsigned  ACC_STEP = 14316557
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam logic [ACC_W:0] STEP_X = (ACC_W+1)'(ACC_STEP);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + STEP_X;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      tick_o <= 1'b0;
    end else begin
      acc    <= sum[ACC_W-1:0];
      tick_o <= sum[ACC_W];
    end
  end

  generate
    if (ACC_STEP < (64'd1 << (ACC_W-1))) begin : g_gap
      // R10
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pad_seq.sv
module pad_seq
  import pad_poll_pkg::*;
#(
  parameter int unsigned BITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic start_i,
  output logic busy_o,
  output logic latch_o,
  output logic pclk_o,
  output logic sample_o,
  output logic commit_o
);
  localparam int unsigned CNT_W = (BITS > 1) ? $clog2(BITS) : 1;

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = (cnt == CNT_W'(BITS-1));
  assign sample_o = tick_i && (st == SQ_FALL);
  assign commit_o = sample_o && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      busy_o  <= 1'b0;
      latch_o <= 1'b0;
      pclk_o  <= 1'b1;
      cnt     <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start_i) begin
          st     <= SQ_ARM;
          busy_o <= 1'b1;
        end
        SQ_ARM: if (tick_i) begin
          latch_o <= 1'b1;
          st      <= SQ_LATCH;
        end
        SQ_LATCH: if (tick_i) begin
          latch_o <= 1'b0;
          cnt     <= '0;
          st      <= SQ_FALL;
        end
        SQ_FALL: if (tick_i) begin
          pclk_o <= 1'b0;
          st     <= SQ_RISE;
        end
        SQ_RISE: if (tick_i) begin
          pclk_o <= 1'b1;
          if (last) begin
            st     <= SQ_IDLE;
            busy_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= SQ_FALL;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  // R5
  latch_in_poll_chk: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> busy_o);
  // R5
  clk_fall_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pclk_o) |-> $past(tick_i));
  // R5
  clk_high_in_latch_chk: assert property (@(posedge clk) disable iff (rst)
    latch_o |-> pclk_o);
endmodule

// File: rtl/pad_lane.sv
module pad_lane #(
  parameter int unsigned BITS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            data_i,
  input  logic            sample_i,
  input  logic            commit_i,
  output logic [BITS-1:0] res_o
);
  logic [BITS-1:0] shreg;
  logic [BITS-1:0] nxt;

  assign nxt = {~data_i, shreg[BITS-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      res_o <= '0;
    end else begin
      if (sample_i) shreg <= nxt;
      if (commit_i) res_o <= nxt;
    end
  end

  // R7
  commit_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> sample_i);
endmodule

// File: rtl/pad_poll_bus.sv
module pad_poll_bus
  import pad_poll_pkg::*;
#(
  parameter int unsigned     WORD_W   = 16,
  parameter int unsigned     PLAYERS  = 2,
  parameter int unsigned     ACC_W    = 32,
  parameter longint unsigned ACC_STEP = 14316557
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_cs,
  input  logic               bus_rd,
  input  logic [2:1]         bus_addr,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               pad_latch,
  output logic               pad_clk,
  input  logic [PLAYERS-1:0] pad_data
);
  localparam int unsigned BITS = WORD_W;

  logic              tick, busy, start, sample, commit;
  logic [BITS-1:0]   res [PLAYERS];
  logic [WORD_W-1:0] rd_val;

  assign start = bus_cs && !bus_rd && (bus_addr == OFS_CTRL);

  pad_tick_gen #(.ACC_W(ACC_W), .ACC_STEP(ACC_STEP)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pad_seq #(.BITS(BITS)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .start_i(start),
    .busy_o(busy), .latch_o(pad_latch), .pclk_o(pad_clk),
    .sample_o(sample), .commit_o(commit)
  );

  generate
    for (genvar p = 0; p < PLAYERS; p++) begin : g_lane
      pad_lane #(.BITS(BITS)) u_lane (
        .clk(clk), .rst(rst), .data_i(pad_data[p]),
        .sample_i(sample), .commit_i(commit), .res_o(res[p])
      );
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFS_CTRL) rd_val = {{(WORD_W-1){1'b0}}, busy};
    for (int k = 0; k < PLAYERS; k++)
      if (bus_addr == 2'(k+1)) rd_val = res[k];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= (bus_cs && bus_rd) ? rd_val : '0;
  end

  // R9
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_cs && bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_pad_poll_bus.sv
module sim_pad_poll_bus;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_cs = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:1]  bus_addr = 2'b00;
  logic [15:0] bus_rdata;
  logic        pad_latch, pad_clk;
  logic [1:0]  pad_data;

  int total = 0;
  int bad = 0;

  logic [15:0] press0 = '0, press1 = '0;
  int          idx = 0;

  int latch_rises = 0, clk_falls = 0;
  int lat_run = 0, last_lat_w = 0, low_run = 0, last_low_w = 0;
  int high_run = 0, last_high_w = 0;
  logic prev_lat = 1'b0, prev_clk = 1'b1;

  always #5 clk = ~clk;

  pad_poll_bus #(.ACC_STEP(64'd1 << 30)) u0 (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pad_latch(pad_latch), .pad_clk(pad_clk), .pad_data(pad_data)
  );

  // controller model: reloads on latch, advances on clock rise
  always @(posedge pad_latch or posedge pad_clk) begin
    if (pad_latch) idx <= 0;
    else           idx <= idx + 1;
  end
  assign pad_data = {(idx < 16) ? ~press1[idx[3:0]] : 1'b1,
                     (idx < 16) ? ~press0[idx[3:0]] : 1'b1};

  always @(negedge clk) begin
    if (!rst) begin
      if (pad_latch && !prev_lat) latch_rises++;
      if (!pad_clk && prev_clk) clk_falls++;
      if (pad_latch) lat_run++;
      else if (prev_lat) begin last_lat_w = lat_run; lat_run = 0; end
      if (!pad_clk) low_run++;
      else if (!prev_clk) begin last_low_w = low_run; low_run = 0; end
      if (pad_clk && !pad_latch && !prev_clk) high_run = 0;
      if (pad_clk && !pad_latch && u0.u_seq.busy_o == 1'b0) high_run = 0;
      prev_lat = pad_latch;
      prev_clk = pad_clk;
    end
  end

  function automatic logic [15:0] expect_word(input logic [15:0] pressed);
    return pressed;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic cs, input logic [1:0] a);
    @(negedge clk);
    bus_cs = cs; bus_rd = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_cs = 1'b0;
  endtask

  task automatic bus_read(input logic cs, input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_cs = cs; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    s = 16'h1;
    for (int n = 0; n < 400 && s[0]; n++) bus_read(1'b1, 2'b00, s);
  endtask

  task automatic poll_and_check(input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [15:0] v;
    press0 = a; press1 = b;
    bus_write(1'b1, 2'b00);
    bus_read(1'b1, 2'b00, v);
    check({"R2 busy after start ", tag}, v, 16'h0001);
    wait_idle();
    bus_read(1'b1, 2'b01, v);
    check({"R6 R7 player1 ", tag}, v, expect_word(a));
    bus_read(1'b1, 2'b10, v);
    check({"R6 R7 player2 ", tag}, v, expect_word(b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int lr0, cf0;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 latch", {15'd0, pad_latch}, 16'h0);
    check("R1 clock", {15'd0, pad_clk}, 16'h1);
    check("R1 rdata", bus_rdata, 16'h0);
    bus_read(1'b1, 2'b00, v); check("R1 busy", v, 16'h0);
    bus_read(1'b1, 2'b01, v); check("R1 player1", v, 16'h0);
    bus_read(1'b1, 2'b10, v); check("R1 player2", v, 16'h0);

    // R6 directed: B only on player 1, R shoulder only on player 2
    lr0 = latch_rises; cf0 = clk_falls;
    poll_and_check(16'h0001, 16'h0800, "B/R");
    check("R4 one latch per poll", 16'(latch_rises - lr0), 16'd1);
    check("R5 sixteen clocks", 16'(clk_falls - cf0), 16'd16);
    // R5 R10 one strobe period is 4 clocks with step 2^30
    check("R5 R10 latch width", 16'(last_lat_w), 16'd4);
    check("R5 R10 clock low width", 16'(last_low_w), 16'd4);

    poll_and_check(16'hFFFF, 16'h0000, "all/none");
    poll_and_check(16'h0010, 16'h8000, "up/bit15");

    // R7 + constrained random patterns
    for (int i = 0; i < 6; i++)
      poll_and_check(16'($urandom), 16'($urandom), "random");

    // R4 start during a running poll is ignored
    lr0 = latch_rises;
    press0 = 16'h0A5C; press1 = 16'h3301;
    bus_write(1'b1, 2'b00);
    repeat (20) @(negedge clk);
    bus_write(1'b1, 2'b00);
    wait_idle();
    repeat (12) @(negedge clk);
    check("R4 latch count", 16'(latch_rises - lr0), 16'd1);
    bus_read(1'b1, 2'b00, v); check("R4 not restarted", v, 16'h0);
    bus_read(1'b1, 2'b01, v); check("R4 player1", v, 16'h0A5C);

    // R3 unselected write and write to other offsets
    lr0 = latch_rises;
    bus_write(1'b0, 2'b00);
    bus_write(1'b1, 2'b01);
    bus_write(1'b1, 2'b10);
    repeat (30) @(negedge clk);
    check("R3 no latch", 16'(latch_rises - lr0), 16'd0);
    bus_read(1'b1, 2'b00, v); check("R3 busy stays 0", v, 16'h0);

    // R8 unused offset, R9 quiet output
    bus_read(1'b1, 2'b11, v); check("R8 offset 3", v, 16'h0);
    bus_read(1'b0, 2'b01, v); check("R9 unselected read", v, 16'h0);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b0; bus_addr = 2'b01;
    @(negedge clk);
    check("R9 write cycle", bus_rdata, 16'h0);
    bus_cs = 1'b0;
    @(negedge clk);
    check("R9 idle", bus_rdata, 16'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule